// File: doc/BRIEF.md
# Wakeup Interrupt Polarity Converter

This block sits between a bank of raw interrupt lines and a downstream interrupt controller that only understands rising-edge and active-high requests. Each line has its own 32-bit configuration word that holds a 3-bit trigger type and an enable. The block synchronizes each input and, when the type asks for it, inverts the line. It then detects edges and presents a conditioned output: a one-cycle pulse for edge types, or a level that is active high for level types.

Software programs the words through a small register port. A write is taken in the cycle it is presented, and read data returns one cycle after the request. A fixed, read-only version word in the same address space tells software that the enable sits inside each per-line word. The edge detector works on the signal after polarity correction. A change of type that flips the polarity while the input is steady therefore yields a single, predictable pulse, which the downstream controller is expected to clear.

Top module: `irq_polarity_conv`

## Requirements
- R1: After reset every configuration word reads 0, so every line is disabled, `irq_out` is all zero and `reg_rvalid` is low.
- R2: The word of line i sits at byte address 0x110 + 4*i. Address bits [1:0] are ignored. All 32 bits written are kept and read back. A read request gives `reg_rvalid` high with the data in the next cycle. Bit 3 is the line enable and bits [2:0] are the trigger type.
- R3: A read of address 0x1000 returns 0x00030200, and writes there change nothing. A read of any other address outside the line words returns 0, and writes there change no line word.
- R4: A line whose enable bit was 0 in the previous cycle drives its output low, whatever its input does.
- R5: Type 100 (level, active high): the output follows the input, with a delay of three clock edges from the edge that samples the input.
- R6: Type 000 (level, active low): the output is the inverse of the input, with the same delay as R5.
- R7: Type 110 (rising edge): each rising transition of the input gives exactly one one-cycle output pulse.
- R8: Type 010 (falling edge): each falling transition of the input gives exactly one one-cycle output pulse.
- R9: Type 111 (dual edge): each transition of the input, rising or falling, gives one one-cycle output pulse.
- R10: The undefined types 001, 011 and 101 hold the output low, even when the line is enabled.
- R11: On an enabled line whose input stays low, a change of type from 110 to 010 gives exactly one one-cycle pulse. A change from 010 to 110 gives none.
- R12: Lines are independent: a write to one word or an input change on one line does not alter the output of another line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read response strobe, one cycle after the request |
| irq_in | input | N_LINES | Raw asynchronous interrupt inputs |
| irq_out | output | N_LINES | Conditioned rising-edge / active-high outputs |

## Verification
The hardest case to reach from the ports is the spurious pulse caused by a polarity flip while the input is steady. Nothing on the input side causes it. It appears only when a register write lands while the synchronized input has been quiet for several cycles. The stimulus first holds the input low long enough to drain the synchronizer. It then rewrites the type from rising to falling and counts output pulses over a window, expecting exactly one. It then rewrites the type back and expects none. A cycle-accurate reference built from the requirements also runs against long stretches of pseudo-random input over a mix of all types.

// File: rtl/irqpc_pkg.sv
package irqpc_pkg;

   typedef enum logic [2:0] {
      TRIG_LVL_LO    = 3'b000,
      TRIG_EDGE_FALL = 3'b010,
      TRIG_LVL_HI    = 3'b100,
      TRIG_EDGE_RISE = 3'b110,
      TRIG_EDGE_BOTH = 3'b111
   } trig_e;

   localparam int unsigned CFG_W      = 32;
   localparam int unsigned TRIG_W     = 3;
   localparam int unsigned CFG_EN_BIT = 3;

   // Types with bit 2 clear are inverted before edge detection.
   function automatic logic trig_inverts(input logic [TRIG_W-1:0] t);
      return ~t[2];
   endfunction

endpackage

// File: rtl/irqpc_sync.sv
module irqpc_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/irqpc_line_cond.sv
module irqpc_line_cond
   import irqpc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_in,
   input  logic [TRIG_W-1:0] trig,
   input  logic              en,
   output logic              cond_out
);

   logic pol;
   logic pol_q;
   logic raw_q;
   logic nxt;
   logic out_q;

   // Polarity-corrected view: edge logic sees it, so a polarity flip on a
   // steady input can itself look like a rising edge.
   assign pol = sync_in ^ trig_inverts(trig);

   always_comb begin
      case (trig)
         TRIG_LVL_LO,
         TRIG_LVL_HI:    nxt = pol;
         TRIG_EDGE_FALL,
         TRIG_EDGE_RISE: nxt = pol & ~pol_q;
         TRIG_EDGE_BOTH: nxt = sync_in ^ raw_q;
         default:        nxt = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q <= 1'b0;
         raw_q <= 1'b0;
         out_q <= 1'b0;
      end else begin
         pol_q <= pol;
         raw_q <= sync_in;
         out_q <= en & nxt;
      end
   end

   assign cond_out = out_q;

endmodule

// File: rtl/irqpc_regfile.sv
module irqpc_regfile
   import irqpc_pkg::*;
#(
   parameter int unsigned N        = 8,
   parameter int unsigned ADDR_W   = 16,
   parameter logic [31:0] CFG_BASE = 32'h0000_0110,
   parameter logic [31:0] VER_ADDR = 32'h0000_1000,
   parameter logic [31:0] VERSION  = 32'h0003_0200
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                valid,
   input  logic                write,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [CFG_W-1:0]    wdata,
   output logic [CFG_W-1:0]    rdata,
   output logic                rvalid,
   output logic [TRIG_W*N-1:0] trig_flat,
   output logic [N-1:0]        en_vec
);

   localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;
   localparam logic [ADDR_W-1:0] BASE_A = CFG_BASE[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(4 * N);

   logic [CFG_W-1:0]  cfg_q [N];
   logic [ADDR_W-1:0] off;
   logic              cfg_hit;
   logic              ver_hit;
   logic [IDX_W-1:0]  idx;
   logic [CFG_W-1:0]  rd_sel;
   logic              rd_req;
   logic              wr_req;

   assign off     = addr - BASE_A;
   assign cfg_hit = (addr >= BASE_A) && (off < SPAN_A);
   assign ver_hit = addr[ADDR_W-1:2] == VER_ADDR[ADDR_W-1:2];
   assign idx     = off[IDX_W+1:2];
   assign rd_req  = valid & ~write;
   assign wr_req  = valid & write & cfg_hit;

   for (genvar i = 0; i < N; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               cfg_q[i] <= '0;
         else if (wr_req && idx == IDX_W'(i))      cfg_q[i] <= wdata;
      end
      assign trig_flat[TRIG_W*i +: TRIG_W] = cfg_q[i][TRIG_W-1:0];
      assign en_vec[i]                     = cfg_q[i][CFG_EN_BIT];
   end

   always_comb begin
      rd_sel = '0;
      if (ver_hit) begin
         rd_sel = VERSION;
      end else if (cfg_hit) begin
         for (int i = 0; i < N; i++)
            if (idx == IDX_W'(i)) rd_sel = cfg_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else begin
         rvalid <= rd_req;
         if (rd_req) rdata <= rd_sel;
      end
   end

endmodule

// File: rtl/irq_polarity_conv.sv
module irq_polarity_conv
   import irqpc_pkg::*;
#(
   parameter int unsigned N_LINES     = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 16,
   parameter logic [31:0] CFG_BASE    = 32'h0000_0110,
   parameter logic [31:0] VER_ADDR    = 32'h0000_1000,
   parameter logic [31:0] VERSION     = 32'h0003_0200
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_valid,
   input  logic               reg_write,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               reg_rvalid,
   input  logic [N_LINES-1:0] irq_in,
   output logic [N_LINES-1:0] irq_out
);

   if (N_LINES < 1 || N_LINES > 256) begin : g_bad_lines
      $error("N_LINES must lie in 1..256");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 14 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie in 14..32");
   end
   if (64'(CFG_BASE) + 64'(4 * N_LINES) > (64'd1 << ADDR_W)) begin : g_bad_map
      $error("line words do not fit the address space");
   end

   logic [TRIG_W*N_LINES-1:0] trig_flat;
   logic [N_LINES-1:0]        en_vec;
   logic [N_LINES-1:0]        sync_q;

   irqpc_regfile #(
      .N        (N_LINES),
      .ADDR_W   (ADDR_W),
      .CFG_BASE (CFG_BASE),
      .VER_ADDR (VER_ADDR),
      .VERSION  (VERSION)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (reg_valid),
      .write     (reg_write),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .rvalid    (reg_rvalid),
      .trig_flat (trig_flat),
      .en_vec    (en_vec)
   );

   irqpc_sync #(
      .W      (N_LINES),
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (irq_in),
      .q     (sync_q)
   );

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      irqpc_line_cond line_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .sync_in  (sync_q[i]),
         .trig     (trig_flat[TRIG_W*i +: TRIG_W]),
         .en       (en_vec[i]),
         .cond_out (irq_out[i])
      );
   end

endmodule

// File: rtl/irqpc_chk.sv
module irqpc_chk #(
   parameter int unsigned N        = 8,
   parameter int unsigned ADDR_W   = 16,
   parameter logic [31:0] VER_ADDR = 32'h0000_1000,
   parameter logic [31:0] VERSION  = 32'h0003_0200
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_valid,
   input logic              reg_write,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_rdata,
   input logic              reg_rvalid,
   input logic [N-1:0]      irq_out,
   input logic [N-1:0]      line_en,
   input logic [3*N-1:0]    line_trig
);

   p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_out == '0 && !reg_rvalid));

   p_read_response_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid && !reg_write) |=> reg_rvalid);

   p_no_stray_response_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_valid && !reg_write) |=> !reg_rvalid);

   p_version_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid && !reg_write && reg_addr[ADDR_W-1:2] == VER_ADDR[ADDR_W-1:2])
      |=> reg_rdata == VERSION);

   for (genvar i = 0; i < N; i++) begin : g_line_chk
      p_disabled_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(line_en[i]) |-> !irq_out[i]);

      p_undefined_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(line_trig[3*i +: 3]) == 3'b001 ||
          $past(line_trig[3*i +: 3]) == 3'b011 ||
          $past(line_trig[3*i +: 3]) == 3'b101) |-> !irq_out[i]);
   end

endmodule

bind irq_polarity_conv irqpc_chk #(
   .N        (N_LINES),
   .ADDR_W   (ADDR_W),
   .VER_ADDR (VER_ADDR),
   .VERSION  (VERSION)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_valid  (reg_valid),
   .reg_write  (reg_write),
   .reg_addr   (reg_addr),
   .reg_rdata  (reg_rdata),
   .reg_rvalid (reg_rvalid),
   .irq_out    (irq_out),
   .line_en    (en_vec),
   .line_trig  (trig_flat)
);

// File: tb/irq_polarity_conv_tb_top.sv
`timescale 1ns/1ps
module irq_polarity_conv_tb_top;

   localparam int N = 8;
   localparam logic [15:0] CFG = 16'h0110;
   localparam logic [15:0] VER = 16'h1000;
   localparam logic [31:0] VERSION = 32'h0003_0200;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_valid = 1'b0;
   logic          reg_write = 1'b0;
   logic [15:0]   reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          reg_rvalid;
   logic [N-1:0]  irq_in = '0;
   logic [N-1:0]  irq_out;

   always #2.5 clk = ~clk;

   irq_polarity_conv #(.N_LINES(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .reg_rvalid(reg_rvalid), .irq_in(irq_in), .irq_out(irq_out)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [N-1:0] exp_q [$];
   logic [31:0]  rd_q [$];
   string        rd_tag_q [$];

   logic [31:0]  m_cfg [N];
   logic [N-1:0] m_s1, m_s2, m_praw, m_polq;
   int           pulse_cnt [N];
   logic [N-1:0] prev_out = '0;

   function automatic string tag_of(input logic [31:0] c);
      if (!c[3]) return "R4";
      case (c[2:0])
         3'b100:  return "R5";
         3'b000:  return "R6";
         3'b110:  return "R7";
         3'b010:  return "R8";
         3'b111:  return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Reference model: expected output after each rising edge
   always @(posedge clk) begin : model
      logic [N-1:0] e;
      logic [2:0]   t;
      logic         pol, v;
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_praw = '0; m_polq = '0;
         for (int i = 0; i < N; i++) m_cfg[i] = '0;
      end else begin
         for (int i = 0; i < N; i++) begin
            t   = m_cfg[i][2:0];
            pol = m_s2[i] ^ ~t[2];
            case (t)
               3'b000, 3'b100: v = pol;
               3'b010, 3'b110: v = pol & ~m_polq[i];
               3'b111:         v = m_s2[i] ^ m_praw[i];
               default:        v = 1'b0;
            endcase
            e[i] = m_cfg[i][3] & v;
            m_polq[i] = pol;
         end
         exp_q.push_back(e);
         m_praw = m_s2; m_s2 = m_s1; m_s1 = irq_in;
         if (reg_valid && reg_write && reg_addr >= CFG && reg_addr < CFG + 16'(4*N))
            m_cfg[(reg_addr - CFG) >> 2] = reg_wdata;
      end
   end

   // Monitor / scoreboard
   always @(negedge clk) begin : monitor
      logic [N-1:0] e;
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         n_chk++;
         if (irq_out !== e) begin
            n_bad++;
            for (int i = 0; i < N; i++)
               if (irq_out[i] !== e[i])
                  $display("FAIL %s/R12 line %0d: actual=%b expected=%b",
                           tag_of(m_cfg[i]), i, irq_out[i], e[i]);
         end
      end
      if (reg_rvalid) begin
         if (rd_q.size() == 0) begin
            check(1'b0, "R2 unrequested response", 1, 0);
         end else begin
            logic [31:0] x;
            string tg;
            x  = rd_q.pop_front();
            tg = rd_tag_q.pop_front();
            check(reg_rdata === x, tg, reg_rdata, x);
         end
      end
      for (int i = 0; i < N; i++)
         if (irq_out[i] && !prev_out[i]) pulse_cnt[i]++;
      prev_out = irq_out;
   end

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [31:0] x, input string tg);
      rd_q.push_back(x);
      rd_tag_q.push_back(tg);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
      @(negedge clk);
      reg_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_counts();
      for (int i = 0; i < N; i++) pulse_cnt[i] = 0;
   endtask

   initial begin : main
      logic [15:0] lfsr;
      for (int i = 0; i < N; i++) pulse_cnt[i] = 0;
      idle(4);
      rst_n = 1'b1;
      @(negedge clk);
      check(irq_out == '0 && !reg_rvalid, "R1 outputs after reset", irq_out, 0);
      for (int i = 0; i < N; i++) rd(CFG + 16'(4*i), 32'h0, "R1 word reset");

      // R3: version word and unmapped space
      rd(VER, VERSION, "R3 version");
      rd(VER + 16'd2, VERSION, "R3 version low bits");
      wr(VER, 32'hFFFF_FFFF);
      rd(VER, VERSION, "R3 version after write");
      rd(16'h0800, 32'h0, "R3 unmapped read");
      wr(CFG + 16'(4*N), 32'hFFFF_FFFF);
      rd(CFG + 16'(4*N), 32'h0, "R3 past last line");
      rd(CFG + 16'(4*(N-1)), 32'h0, "R3 last line untouched");

      // R2: full word kept, low address bits ignored
      wr(CFG + 16'd12, 32'hCAFE_F0A2);
      rd(CFG + 16'd12, 32'hCAFE_F0A2, "R2 readback");
      wr(CFG + 16'd13, 32'h1234_5676);
      rd(CFG + 16'd12, 32'h1234_5676, "R2 low address bits");

      // Mixed configuration
      wr(CFG + 16'd0,  32'h0000_000C);   // level high
      wr(CFG + 16'd4,  32'h0000_0008);   // level low
      wr(CFG + 16'd8,  32'h0000_000E);   // rising
      wr(CFG + 16'd12, 32'h0000_000A);   // falling
      wr(CFG + 16'd16, 32'h0000_000F);   // dual
      wr(CFG + 16'd20, 32'h0000_0009);   // undefined 001
      wr(CFG + 16'd24, 32'h0000_000B);   // undefined 011
      wr(CFG + 16'd28, 32'h0000_0006);   // rising, disabled
      idle(4);
      check(irq_out[1] == 1'b1, "R6 low input asserts", irq_out[1], 1);
      check(irq_out[0] == 1'b0, "R5 low input idle", irq_out[0], 0);

      // One clean high/low step on all lines
      clear_counts();
      irq_in = '1;
      idle(6);
      check(irq_out[0] == 1'b1, "R5 high input asserts", irq_out[0], 1);
      check(irq_out[1] == 1'b0, "R6 high input deasserts", irq_out[1], 0);
      irq_in = '0;
      idle(6);
      check(pulse_cnt[2] == 1, "R7 one pulse per rise", pulse_cnt[2], 1);
      check(pulse_cnt[3] == 1, "R8 one pulse per fall", pulse_cnt[3], 1);
      check(pulse_cnt[4] == 2, "R9 pulse per transition", pulse_cnt[4], 2);
      check(pulse_cnt[5] + pulse_cnt[6] == 0, "R10 undefined silent",
            pulse_cnt[5] + pulse_cnt[6], 0);
      check(pulse_cnt[7] == 0, "R4 disabled silent", pulse_cnt[7], 0);

      // Pseudo-random stretch, checked cycle by cycle by the model
      lfsr = 16'hACE1;
      for (int k = 0; k < 600; k++) begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (k % 3 == 0) irq_in = lfsr[N-1:0];
      end

      // R11: polarity flip on a steady low input
      irq_in = '0;
      idle(6);
      check(irq_out[2] == 1'b0, "R11 quiet before flip", irq_out[2], 0);
      clear_counts();
      wr(CFG + 16'd8, 32'h0000_000A);
      idle(6);
      check(pulse_cnt[2] == 1, "R11 single spurious pulse", pulse_cnt[2], 1);
      check(irq_out[2] == 1'b0, "R11 pulse self-clears", irq_out[2], 0);
      check(pulse_cnt[4] == 0, "R12 other line unaffected", pulse_cnt[4], 0);
      clear_counts();
      wr(CFG + 16'd8, 32'h0000_000E);
      idle(6);
      check(pulse_cnt[2] == 0, "R11 reverse flip silent", pulse_cnt[2], 0);

      // R10: type 101 with high input; R4: disabling an active level line
      irq_in[0] = 1'b1;
      idle(4);
      wr(CFG + 16'd0, 32'h0000_000D);
      idle(3);
      check(irq_out[0] == 1'b0, "R10 type 101 held low", irq_out[0], 0);
      check(irq_out[1] == 1'b1, "R6 line 1 active before disable", irq_out[1], 1);
      wr(CFG + 16'd4, 32'h0000_0000);
      idle(2);
      check(irq_out[1] == 1'b0, "R4 disable forces low", irq_out[1], 0);

      idle(4);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : watchdog
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule